// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Strobe Timer

This block drives the read and write strobes (both active low) of one parallel ATA channel for programmed-I/O and multiword DMA transfers. A 32-bit timing word sets every phase length. Data transfers and task-file register accesses each have their own active count, inactive count and first-cycle setup count. Every count N gives a phase of N+1 clocks.

A transfer starts with a one-clock `start` request while the block is idle. At that moment the block captures the timing word, the burst length, the access class (`cmd_sel`) and the direction. It then runs one setup phase and repeats active/inactive pairs until the burst is complete. `busy` covers the whole burst and `done` pulses once when it ends. A timing word that selects Ultra DMA is refused with a one-clock error pulse.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, both strobes are high (1) and `busy`, `done`, `mode_err` and `fifo_en` are low.
- R2: For a data access (`cmd_sel`=0), each active phase lasts word[8:4]+1 clocks and each inactive phase lasts word[3:0]+1 clocks.
- R3: For a task-file access (`cmd_sel`=1), each active phase lasts word[17:13]+1 clocks and each inactive phase lasts word[12:9]+1 clocks. The data count fields have no effect.
- R4: One setup phase with both strobes high comes before the first active phase, and only before that one. It lasts word[24:22]+1 clocks for data accesses and word[27:25]+1 clocks for task-file accesses.
- R5: A burst contains `burst_len`+1 active/inactive cycles.
- R6: The strobe is `diow_n` when `wr`=1 and `dior_n` when `wr`=0. The two strobes are never low together.
- R7: A `start` while word[28]=1 starts no burst. `busy` stays low, both strobes stay high, and `mode_err` is high for the one clock after the request.
- R8: The timing word and the other request inputs are captured when `start` is accepted. Changes to them while `busy` is high, including a new `start`, have no effect on the burst in progress.
- R9: `busy` is high from the clock after acceptance through the last inactive clock. `done` is high for exactly the next clock, while `busy` is low. While `busy` is low, both strobes are high.
- R10: `fifo_en` is high during a burst only for a data access with word[29]=1 (multiword DMA) and word[31]=1. In every other case it is low, so PIO and task-file accesses never enable the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_word | input | 32 | Packed phase counts and mode bits |
| start | input | 1 | Burst request, taken only when idle |
| burst_len | input | LEN_W | Number of cycles minus one |
| cmd_sel | input | 1 | 1 = task-file register access, 0 = data |
| wr | input | 1 | 1 = write strobe, 0 = read strobe |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock pulse at burst end |
| mode_err | output | 1 | One-clock pulse for a refused Ultra DMA request |
| fifo_en | output | 1 | FIFO enable for the burst in progress |

## Verification
The assertions check four things on every clock: the two strobes are never low together, both strobes are high and `fifo_en` is low whenever the block is idle, `done` is a single pulse that coincides with the fall of `busy`, and an error pulse never overlaps a burst. Only the bench scenarios can show the exact phase lengths chosen by each field, the single setup phase, the cycle count per burst, the field selection between data and task-file accesses, and the freezing of the timing word while a burst runs. They are observed by counting strobe and busy clocks against lengths computed from the field values.

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      timing_word,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             cmd_sel,
  input  logic             wr,
  output logic             dior_n,
  output logic             diow_n,
  output logic             busy,
  output logic             done,
  output logic             mode_err,
  output logic             fifo_en
);
  localparam int CW = 5;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_INACT, S_DONE} st_t;

  st_t              st;
  logic [31:0]      tw_q;
  logic             cmd_q, wr_q;
  logic [LEN_W-1:0] rem;
  logic [CW-1:0]    cnt;

  wire [CW-1:0] act_len   = cmd_q ? tw_q[17:13] : tw_q[8:4];
  wire [CW-1:0] inact_len = cmd_q ? {1'b0, tw_q[12:9]} : {1'b0, tw_q[3:0]};
  wire [CW-1:0] setup_in  = cmd_sel ? {2'b0, timing_word[27:25]} : {2'b0, timing_word[24:22]};
  wire          idle      = (st == S_IDLE);
  wire          udma_req  = timing_word[28];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tw_q     <= '0;
      cmd_q    <= 1'b0;
      wr_q     <= 1'b0;
      rem      <= '0;
      cnt      <= '0;
      mode_err <= 1'b0;
    end else begin
      mode_err <= idle && start && udma_req;
      case (st)
        S_IDLE:
          if (start && !udma_req) begin
            tw_q  <= timing_word;
            cmd_q <= cmd_sel;
            wr_q  <= wr;
            rem   <= burst_len;
            cnt   <= setup_in;
            st    <= S_SETUP;
          end
        S_SETUP:
          if (cnt == '0) begin
            st  <= S_ACT;
            cnt <= act_len;
          end else cnt <= cnt - 1'b1;
        S_ACT:
          if (cnt == '0) begin
            st  <= S_INACT;
            cnt <= inact_len;
          end else cnt <= cnt - 1'b1;
        S_INACT:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (rem == '0) st <= S_DONE;
          else begin
            rem <= rem - 1'b1;
            cnt <= act_len;
            st  <= S_ACT;
          end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dior_n  = !((st == S_ACT) && !wr_q);
  assign diow_n  = !((st == S_ACT) && wr_q);
  assign busy    = (st == S_SETUP) || (st == S_ACT) || (st == S_INACT);
  assign done    = (st == S_DONE);
  assign fifo_en = busy && !cmd_q && tw_q[29] && tw_q[31];
endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic dior_n,
  input logic diow_n,
  input logic busy,
  input logic done,
  input logic mode_err,
  input logic fifo_en
);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));
  assert_idle_strobes_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dior_n && diow_n));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  assert_busy_fall_gives_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_err_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !busy);
  assert_fifo_idle_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fifo_en);
endmodule

bind ata_strobe_timer ata_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dior_n(dior_n), .diow_n(diow_n),
  .busy(busy), .done(done), .mode_err(mode_err), .fifo_en(fifo_en)
);

// File: tb/tb_ata_strobe_timer.sv
module tb_ata_strobe_timer;
  localparam int LEN_W = 8;
  localparam int NV = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      timing_word = '0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] burst_len = '0;
  logic             cmd_sel = 1'b0;
  logic             wr = 1'b0;
  logic             dior_n, diow_n, busy, done, mode_err, fifo_en;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ata_strobe_timer #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .timing_word(timing_word), .start(start),
    .burst_len(burst_len), .cmd_sel(cmd_sel), .wr(wr), .dior_n(dior_n),
    .diow_n(diow_n), .busy(busy), .done(done), .mode_err(mode_err), .fifo_en(fifo_en)
  );

  // word, len, cmd, wr | busy clocks, strobe clocks, clocks before first strobe, fifo
  localparam logic [31:0] V_WORD  [NV] = '{32'h0000_0021, 32'h0080_0000, 32'h0200_2657, 32'hA000_0000,
                                           32'hA000_0010, 32'h8040_0002, 32'h0000_01FF, 32'h0E03_FE00};
  localparam int          V_LEN   [NV] = '{0, 2, 1, 3, 1, 0, 0, 0};
  localparam logic        V_CMD   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic        V_WR    [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int          V_BUSY  [NV] = '{6, 9, 14, 9, 7, 6, 49, 56};
  localparam int          V_ACT   [NV] = '{3, 3, 4, 4, 4, 1, 32, 32};
  localparam int          V_FIRST [NV] = '{1, 3, 2, 1, 1, 2, 1, 8};
  localparam logic        V_FIFO  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input int len, input logic c, input logic d,
                     input int e_busy, input int e_act, input int e_first, input logic e_fifo,
                     input bool_mid);
    int nb = 0, na = 0, no = 0, first = -1, fbad = 0;
    @(negedge clk);
    timing_word = w; burst_len = LEN_W'(len); cmd_sel = c; wr = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && nb < 5000) begin
      nb++;
      if (d ? !diow_n : !dior_n) begin
        na++;
        if (first < 0) first = nb - 1;
      end
      if (d ? !dior_n : !diow_n) no++;
      if (fifo_en !== e_fifo) fbad++;
      @(negedge clk);
      if (bool_mid && nb == 2) begin
        timing_word = 32'h0E03_FFFF; burst_len = '1; cmd_sel = ~c; wr = ~d; start = 1'b1;
      end else start = 1'b0;
    end
    chk(nb == e_busy, "R2 R3 R4 R5 R8 busy length", nb, e_busy);
    chk(na == e_act, "R2 R3 R5 R8 strobe low clocks", na, e_act);
    chk(first == e_first, "R4 setup clocks before first strobe", first, e_first);
    chk(no == 0, "R6 opposite strobe low clocks", no, 0);
    chk(fbad == 0, "R10 fifo_en mismatch clocks", fbad, 0);
    chk(done === 1'b1 && dior_n && diow_n, "R9 done after last inactive", done, 1);
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0 && busy === 1'b0, "R9 done single clock, no retrigger", {done, busy}, 0);
  endtask

  typedef bit bool;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dior_n && diow_n && !busy && !done && !mode_err && !fifo_en, "R1 reset state",
        {dior_n, diow_n, busy, done, mode_err, fifo_en}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run(V_WORD[i], V_LEN[i], V_CMD[i], V_WR[i], V_BUSY[i], V_ACT[i], V_FIRST[i], V_FIFO[i], 1'b0);

    // R8: inputs changed and start pulsed mid-burst
    run(32'h0000_0021, 0, 1'b0, 1'b0, 6, 3, 1, 1'b0, 1'b1);

    // R7: Ultra DMA request refused
    @(negedge clk);
    timing_word = 32'h1000_0021; burst_len = '0; cmd_sel = 1'b0; wr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mode_err === 1'b1 && !busy && dior_n && diow_n, "R7 error pulse, no burst",
        {mode_err, busy}, 2'b10);
    @(negedge clk);
    chk(mode_err === 1'b0 && !busy && dior_n && diow_n, "R7 error clears, still idle",
        {mode_err, busy}, 0);

    // a normal burst still works after the refusal
    run(32'h0000_0021, 0, 1'b0, 1'b1, 6, 3, 1, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule